// File: doc/BRIEF.md
# PWM Buffer Transfer Gate with Interrupt Skipping

This block holds the three-stage compare update path of one complementary-PWM timer channel. Software writes a buffer register. The buffer is then copied into a temporary register, and the temporary register is copied into the general (compare) register on every crest event of an external up/down counter. A two-bit transfer mode decides when the buffer-to-temporary copy may happen: on every cycle, never, or only inside a window that the crest and trough interrupt-skipping counters open.

Each skip source has its own enable and a 3-bit skip count. An enabled source with a non-zero count counts its own events and raises a one-cycle interrupt request on every Nth event. The transfer window is a two-state machine. It is WIN_CLOSED after reset. The transition WIN_CLOSED to WIN_OPEN is taken when any skip source fires. The transition WIN_OPEN to WIN_CLOSED is taken on a counted event that does not fire, or when no source is active. A firing event while in WIN_OPEN keeps the machine in WIN_OPEN. When the linked mode is selected but no skip source is active, the window never opens and the temporary register keeps its value.

Top module: `pwm_xfer_gate`

## Requirements
- R1: A cycle with `buf_wr_en` high loads `buf_wr_data` into `buf_q` at that clock edge.
- R2: With `xfer_mode` 2'b00 or 2'b11, `tmp_q` takes the value `buf_q` held before each clock edge, so a buffer write reaches `tmp_q` one cycle later.
- R3: With `xfer_mode` 2'b01, `tmp_q` never changes.
- R4: With `xfer_mode` 2'b10, `tmp_q` loads `buf_q` only at edges where `xfer_window` is already high.
- R5: With `xfer_mode` 2'b10 and no active skip source, `tmp_q` never changes. A source is active when its enable is 1 and its skip count is non-zero.
- R6: An active source with skip count N (1 to 7) counts its events from 0. It pulses its interrupt output for one cycle after the Nth event and then restarts from 0. An inactive source never raises its interrupt.
- R7: `xfer_window` goes high after an event at which any source fires. It stays high through further firing events. It goes low after a counted event that does not fire, or after any cycle in which no source is active.
- R8: Every crest event loads the previous `tmp_q` into `gen_q`, whatever the mode. Without a crest event, `gen_q` holds.
- R9: A cycle with `rst` high clears every register and counter and closes the window at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| crest_evt | input | 1 | One-cycle pulse at the counter crest |
| trough_evt | input | 1 | One-cycle pulse at the counter trough |
| buf_wr_en | input | 1 | Buffer write strobe |
| buf_wr_data | input | DATA_W | Buffer write data |
| xfer_mode | input | 2 | 00 normal, 01 hold, 10 linked to skipping, 11 same as 00 |
| crest_skip_en | input | 1 | Crest skip source enable |
| crest_skip_cnt | input | SKIP_W | Crest skip count |
| trough_skip_en | input | 1 | Trough skip source enable |
| trough_skip_cnt | input | SKIP_W | Trough skip count |
| buf_q | output | DATA_W | Buffer register |
| tmp_q | output | DATA_W | Temporary register |
| gen_q | output | DATA_W | General (compare) register |
| crest_irq | output | 1 | Skipped crest interrupt request |
| trough_irq | output | 1 | Skipped trough interrupt request |
| xfer_window | output | 1 | Transfer-enabled window is open |

## Verification
The gate is driven by the same sequence of buffer writes and crest events in each of the four modes. This separates free copying, held copying and window-bound copying. Linked mode is tried three ways: with skipping off, with a zero count, and with a crest count of 2 and a trough count of 1. These show that the window opens only on firing events, closes on a non-firing counted event, and stays open when a second source fires. A run of seven crest events with a count of 7 checks the widest skip, and a reset in mid-run checks that all state clears.

// File: rtl/pwm_xfer_pkg.sv
package pwm_xfer_pkg;
    typedef enum logic [1:0] {
        XM_NORMAL = 2'b00,
        XM_HOLD   = 2'b01,
        XM_LINKED = 2'b10,
        XM_SPARE  = 2'b11
    } xfer_mode_e;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_e;
endpackage

// File: rtl/skip_counter.sv
module skip_counter #(
    parameter int SKIP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic              en,
    input  logic [SKIP_W-1:0] limit,
    output logic              active,
    output logic              counted,
    output logic              fire,
    output logic              irq
);
    localparam int CW = SKIP_W + 1;

    logic [SKIP_W-1:0] count_q;
    logic [CW-1:0]     count_nxt;

    always_comb begin
        active    = en && (limit != '0);
        counted   = evt && active;
        count_nxt = {1'b0, count_q} + CW'(1);
        // >= rather than == recovers if the limit is lowered mid-count
        fire      = counted && (count_nxt >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= fire;
            if (!active || fire)
                count_q <= '0;
            else if (counted)
                count_q <= count_nxt[SKIP_W-1:0];
        end
    end
endmodule

// File: rtl/xfer_window_fsm.sv
module xfer_window_fsm
    import pwm_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic any_active,
    input  logic any_counted,
    input  logic any_fire,
    output logic window
);
    win_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_CLOSED: if (any_active && any_fire) state_d = WIN_OPEN;
            WIN_OPEN: begin
                if (!any_active)
                    state_d = WIN_CLOSED;
                else if (any_counted && !any_fire)
                    state_d = WIN_CLOSED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WIN_CLOSED;
        else     state_q <= state_d;
    end

    always_comb window = (state_q == WIN_OPEN);
endmodule

// File: rtl/stage_regs.sv
module stage_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              copy_tmp,
    input  logic              copy_gen,
    output logic [DATA_W-1:0] buf_q,
    output logic [DATA_W-1:0] tmp_q,
    output logic [DATA_W-1:0] gen_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            tmp_q <= '0;
            gen_q <= '0;
        end else begin
            if (wr_en)    buf_q <= wr_data;
            if (copy_tmp) tmp_q <= buf_q;
            if (copy_gen) gen_q <= tmp_q;
        end
    end
endmodule

// File: rtl/pwm_xfer_gate.sv
module pwm_xfer_gate
    import pwm_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SKIP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              crest_evt,
    input  logic              trough_evt,
    input  logic              buf_wr_en,
    input  logic [DATA_W-1:0] buf_wr_data,
    input  logic [1:0]        xfer_mode,
    input  logic              crest_skip_en,
    input  logic [SKIP_W-1:0] crest_skip_cnt,
    input  logic              trough_skip_en,
    input  logic [SKIP_W-1:0] trough_skip_cnt,
    output logic [DATA_W-1:0] buf_q,
    output logic [DATA_W-1:0] tmp_q,
    output logic [DATA_W-1:0] gen_q,
    output logic              crest_irq,
    output logic              trough_irq,
    output logic              xfer_window
);
    localparam int NSRC = 2;   // index 0 crest, 1 trough

    logic [NSRC-1:0]   src_evt, src_en, src_active, src_counted, src_fire, src_irq;
    logic [SKIP_W-1:0] src_lim [NSRC];
    logic              any_active, copy_tmp;
    xfer_mode_e        mode;

    always_comb begin
        src_evt    = {trough_evt, crest_evt};
        src_en     = {trough_skip_en, crest_skip_en};
        src_lim[0] = crest_skip_cnt;
        src_lim[1] = trough_skip_cnt;
    end

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        skip_counter #(.SKIP_W(SKIP_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .evt     (src_evt[gi]),
            .en      (src_en[gi]),
            .limit   (src_lim[gi]),
            .active  (src_active[gi]),
            .counted (src_counted[gi]),
            .fire    (src_fire[gi]),
            .irq     (src_irq[gi])
        );
    end

    assign any_active = |src_active;
    assign crest_irq  = src_irq[0];
    assign trough_irq = src_irq[1];

    xfer_window_fsm u_win (
        .clk         (clk),
        .rst         (rst),
        .any_active  (any_active),
        .any_counted (|src_counted),
        .any_fire    (|src_fire),
        .window      (xfer_window)
    );

    always_comb begin
        mode = xfer_mode_e'(xfer_mode);
        unique case (mode)
            XM_HOLD:   copy_tmp = 1'b0;
            XM_LINKED: copy_tmp = xfer_window && any_active;
            default:   copy_tmp = 1'b1;
        endcase
    end

    stage_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (buf_wr_en),
        .wr_data  (buf_wr_data),
        .copy_tmp (copy_tmp),
        .copy_gen (crest_evt),
        .buf_q    (buf_q),
        .tmp_q    (tmp_q),
        .gen_q    (gen_q)
    );
endmodule

// File: rtl/pwm_xfer_gate_chk.sv
module pwm_xfer_gate_chk #(
    parameter int DATA_W = 16,
    parameter int SKIP_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              crest_evt,
    input logic              trough_evt,
    input logic [1:0]        xfer_mode,
    input logic              crest_skip_en,
    input logic [SKIP_W-1:0] crest_skip_cnt,
    input logic              trough_skip_en,
    input logic [SKIP_W-1:0] trough_skip_cnt,
    input logic [DATA_W-1:0] tmp_q,
    input logic [DATA_W-1:0] gen_q,
    input logic              crest_irq,
    input logic              trough_irq,
    input logic              xfer_window
);
    logic skip_on;
    assign skip_on = (crest_skip_en && crest_skip_cnt != '0) ||
                     (trough_skip_en && trough_skip_cnt != '0);

    // R3
    hold_mode_tmp_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_mode == 2'b01) |=> $stable(tmp_q));

    // R4
    linked_closed_tmp_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_mode == 2'b10 && !xfer_window) |=> $stable(tmp_q));

    // R5
    linked_off_tmp_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_mode == 2'b10 && !skip_on) |=> $stable(tmp_q));

    // R6
    crest_irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !crest_evt |=> !crest_irq);

    // R6
    trough_irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !trough_evt |=> !trough_irq);

    // R7
    window_open_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_window) |-> (crest_irq || trough_irq));

    // R8
    gen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !crest_evt |=> $stable(gen_q));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (tmp_q == '0 && gen_q == '0 && !xfer_window && !crest_irq && !trough_irq));
endmodule

bind pwm_xfer_gate pwm_xfer_gate_chk #(.DATA_W(DATA_W), .SKIP_W(SKIP_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .crest_evt       (crest_evt),
    .trough_evt      (trough_evt),
    .xfer_mode       (xfer_mode),
    .crest_skip_en   (crest_skip_en),
    .crest_skip_cnt  (crest_skip_cnt),
    .trough_skip_en  (trough_skip_en),
    .trough_skip_cnt (trough_skip_cnt),
    .tmp_q           (tmp_q),
    .gen_q           (gen_q),
    .crest_irq       (crest_irq),
    .trough_irq      (trough_irq),
    .xfer_window     (xfer_window)
);

// File: tb/pwm_xfer_gate_test.sv
module pwm_xfer_gate_test;
    localparam int DW = 16;
    localparam int SW = 3;
    localparam int NV = 21;

    typedef struct packed {
        logic [3:0]    req;
        logic [1:0]    mode;
        logic          ce;
        logic [SW-1:0] cc;
        logic          te;
        logic [SW-1:0] tc;
        logic          cev;
        logic          tev;
        logic          wr;
        logic [DW-1:0] wd;
        logic [DW-1:0] etmp;
        logic [DW-1:0] egen;
        logic          ecirq;
        logic          etirq;
        logic          ewin;
    } vec_t;

    // req: R2, R3, R4, R5, R6, R7, R8
    localparam vec_t VECS [NV] = '{
        '{4'd2, 2'b00, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h11, 16'h00, 16'h00, 1'b0, 1'b0, 1'b0},
        '{4'd2, 2'b00, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 16'h00, 16'h11, 16'h00, 1'b0, 1'b0, 1'b0},
        '{4'd8, 2'b00, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h00, 16'h11, 16'h11, 1'b0, 1'b0, 1'b0},
        '{4'd3, 2'b01, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h22, 16'h11, 16'h11, 1'b0, 1'b0, 1'b0},
        '{4'd3, 2'b01, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 16'h00, 16'h11, 16'h11, 1'b0, 1'b0, 1'b0},
        '{4'd8, 2'b01, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h00, 16'h11, 16'h11, 1'b0, 1'b0, 1'b0},
        '{4'd5, 2'b10, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 16'h00, 16'h11, 16'h11, 1'b0, 1'b0, 1'b0},
        '{4'd5, 2'b10, 1'b1, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h00, 16'h11, 16'h11, 1'b0, 1'b0, 1'b0},
        '{4'd6, 2'b10, 1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h00, 16'h11, 16'h11, 1'b0, 1'b0, 1'b0},
        '{4'd7, 2'b10, 1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h00, 16'h11, 16'h11, 1'b1, 1'b0, 1'b1},
        '{4'd4, 2'b10, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 16'h00, 16'h22, 16'h11, 1'b0, 1'b0, 1'b1},
        '{4'd4, 2'b10, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h33, 16'h22, 16'h11, 1'b0, 1'b0, 1'b1},
        '{4'd7, 2'b10, 1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 16'h00, 16'h33, 16'h22, 1'b0, 1'b0, 1'b0},
        '{4'd4, 2'b10, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h44, 16'h33, 16'h22, 1'b0, 1'b0, 1'b0},
        '{4'd4, 2'b10, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 16'h00, 16'h33, 16'h22, 1'b0, 1'b0, 1'b0},
        '{4'd7, 2'b10, 1'b1, 3'd2, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 16'h00, 16'h33, 16'h22, 1'b0, 1'b1, 1'b1},
        '{4'd4, 2'b10, 1'b1, 3'd2, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 16'h00, 16'h44, 16'h22, 1'b0, 1'b0, 1'b1},
        '{4'd7, 2'b10, 1'b1, 3'd2, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 16'h00, 16'h44, 16'h22, 1'b0, 1'b1, 1'b1},
        '{4'd6, 2'b00, 1'b1, 3'd2, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 16'h00, 16'h44, 16'h44, 1'b1, 1'b0, 1'b1},
        '{4'd7, 2'b11, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h55, 16'h44, 16'h44, 1'b0, 1'b0, 1'b0},
        '{4'd2, 2'b11, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 16'h00, 16'h55, 16'h44, 1'b0, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          crest_evt = 1'b0, trough_evt = 1'b0, buf_wr_en = 1'b0;
    logic [DW-1:0] buf_wr_data = '0;
    logic [1:0]    xfer_mode = 2'b00;
    logic          crest_skip_en = 1'b0, trough_skip_en = 1'b0;
    logic [SW-1:0] crest_skip_cnt = '0, trough_skip_cnt = '0;
    logic [DW-1:0] buf_q, tmp_q, gen_q;
    logic          crest_irq, trough_irq, xfer_window;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwm_xfer_gate #(.DATA_W(DW), .SKIP_W(SW)) uut (
        .clk(clk), .rst(rst), .crest_evt(crest_evt), .trough_evt(trough_evt),
        .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data), .xfer_mode(xfer_mode),
        .crest_skip_en(crest_skip_en), .crest_skip_cnt(crest_skip_cnt),
        .trough_skip_en(trough_skip_en), .trough_skip_cnt(trough_skip_cnt),
        .buf_q(buf_q), .tmp_q(tmp_q), .gen_q(gen_q),
        .crest_irq(crest_irq), .trough_irq(trough_irq), .xfer_window(xfer_window)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    // drive after the falling edge, then sample 1 ns after the rising edge
    task automatic step();
        @(posedge clk);
        #1;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        crest_evt = 1'b0; trough_evt = 1'b0; buf_wr_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        step();
        rst = 1'b0;
        // R9 reset state
        check("R9 buf after reset", 32'(buf_q), 32'h0);
        check("R9 tmp after reset", 32'(tmp_q), 32'h0);
        check("R9 gen after reset", 32'(gen_q), 32'h0);
        check("R9 window after reset", 32'(xfer_window), 32'h0);

        for (int i = 0; i < NV; i++) begin
            xfer_mode       = VECS[i].mode;
            crest_skip_en   = VECS[i].ce;
            crest_skip_cnt  = VECS[i].cc;
            trough_skip_en  = VECS[i].te;
            trough_skip_cnt = VECS[i].tc;
            crest_evt       = VECS[i].cev;
            trough_evt      = VECS[i].tev;
            buf_wr_en       = VECS[i].wr;
            buf_wr_data     = VECS[i].wd;
            @(posedge clk);
            #1;
            check($sformatf("R%0d row %0d tmp", VECS[i].req, i), 32'(tmp_q), 32'(VECS[i].etmp));
            check($sformatf("R%0d row %0d gen", VECS[i].req, i), 32'(gen_q), 32'(VECS[i].egen));
            check($sformatf("R%0d row %0d crest_irq", VECS[i].req, i), 32'(crest_irq), 32'(VECS[i].ecirq));
            check($sformatf("R%0d row %0d trough_irq", VECS[i].req, i), 32'(trough_irq), 32'(VECS[i].etirq));
            check($sformatf("R%0d row %0d window", VECS[i].req, i), 32'(xfer_window), 32'(VECS[i].ewin));
            @(negedge clk);
            idle_inputs();
        end

        // R1 write lands in buf_q at the same edge; R3 hold keeps tmp
        xfer_mode = 2'b01; buf_wr_en = 1'b1; buf_wr_data = 16'h66;
        step();
        idle_inputs();
        check("R1 buf after write", 32'(buf_q), 32'h66);
        check("R3 tmp held", 32'(tmp_q), 32'h55);

        // R6 widest skip count: irq only after the 7th crest event
        xfer_mode = 2'b00; crest_skip_en = 1'b1; crest_skip_cnt = 3'd7;
        for (int k = 1; k <= 7; k++) begin
            crest_evt = 1'b1;
            step();
            crest_evt = 1'b0;
            check($sformatf("R6 crest_irq after event %0d of 7", k), 32'(crest_irq), (k == 7) ? 32'h1 : 32'h0);
        end
        check("R7 window after count-7 fire", 32'(xfer_window), 32'h1);

        // R9 mid-run reset
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R9 buf after mid reset", 32'(buf_q), 32'h0);
        check("R9 tmp after mid reset", 32'(tmp_q), 32'h0);
        check("R9 gen after mid reset", 32'(gen_q), 32'h0);
        check("R9 window after mid reset", 32'(xfer_window), 32'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule